// File: doc/BRIEF.md
# Fixed-Latency Arbitrated Line Memory

This block is a word-addressed backing store whose words are grouped four to a line. A requester reaches it through a polled interface. Each cycle the requester presents a request with its own non-zero ID, and it keeps presenting that request until the block answers `done`. Any request can be a single-word or a whole-line access, and either a read or a write.

Only one requester is served at a time. The first requester to poll an idle memory becomes its owner. Polls from any other ID are answered "not done" and have no effect until the owner's access finishes. Every access costs the same fixed number of owner polls (`DELAY`) before the completing poll. When an access finishes, ownership is released and the countdown is reloaded, so the next requester waits the full latency again.

Addresses arrive as signed values. They wrap into the memory modulo its size, and negative values wrap too. An ID of zero is reserved as "no requester" and is refused with an error flag.

Top module: `lat_mem`

## Requirements
- R1: After reset no requester owns the memory, `done` and `err` are low, and every stored word reads back as zero.
- R2: A valid poll with a non-zero ID takes ownership when no requester owns the memory. `done` is only ever high on a valid poll with a non-zero ID.
- R3: With latency `DELAY`, the owner's first `DELAY` polls return `done` low and leave the memory unchanged. Its next poll performs the access and returns `done` high.
- R4: While one ID owns the memory, polls from any other non-zero ID return `done` low, write nothing and do not advance the owner's countdown.
- R5: On completion ownership is released and the countdown is reloaded. A requester that was waiting then needs its own `DELAY` polls plus one, and with `DELAY` greater than zero two completions are never on adjacent cycles.
- R6: A valid poll with ID zero raises `err` in that cycle, never raises `done`, writes nothing and does not take or disturb ownership.
- R7: A completing word write (`req_wr`=1, `req_line`=0) stores `req_wdata` at the wrapped address. A completing word read (`req_wr`=0) returns the stored word on `rdata` in the same cycle as `done`.
- R8: Line accesses (`req_line`=1) act on line number (wrapped address / 4) and ignore the two low address bits. Word k of the line sits at bits [32k+31:32k] of `req_wline` and `rline`. A line read returns all four words in the cycle of `done`.
- R9: `req_addr` is a 16-bit two's-complement value that maps to ((a mod 2^ADDR_W) + 2^ADDR_W) mod 2^ADDR_W. Values above the memory size and negative values both wrap.
- R10: Cycles with `req_valid` low do not advance the countdown and do not change ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A poll is presented this cycle |
| req_id | input | ID_W | Requester ID; zero means no requester |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_line | input | 1 | 1 = whole-line access, 0 = single word |
| req_addr | input | AIN_W | Signed word address, wrapped into range |
| req_wdata | input | DATA_W | Word write data |
| req_wline | input | 4*DATA_W | Line write data, word k at bits [k*DATA_W +: DATA_W] |
| done | output | 1 | Access performed this cycle |
| err | output | 1 | Poll refused because the ID is zero |
| rdata | output | DATA_W | Word read data, valid only with `done` |
| rline | output | 4*DATA_W | Line read data, valid only with `done` |

## Verification
The properties assume that a requester holds its ID on the bus while it polls, and that `req_valid` is never left undriven after reset. The latency property also assumes that only refused or non-completing polls occur between completions, which any legal polling sequence satisfies. The stimulus always drives every input from a task at the falling edge and never leaves a request field unknown. It interleaves two IDs during one access, injects zero-ID polls and idle cycles inside an access, and places addresses above the top of the memory, negative addresses and maximum-value addresses, so the wrap and ownership rules are exercised under those assumptions.

// File: rtl/lat_mem_pkg.sv
package lat_mem_pkg;
   // words per line and the bits that select a word within a line
   localparam int LINE_WORDS = 4;
   localparam int OFS_W      = 2;

   typedef enum logic {
      ACC_WORD = 1'b0,
      ACC_LINE = 1'b1
   } acc_kind_e;
endpackage

// File: rtl/lat_mem_addr_wrap.sv
module lat_mem_addr_wrap
   import lat_mem_pkg::*;
#(
   parameter int AIN_W  = 16,
   parameter int ADDR_W = 8,
   localparam int LIDX_W = ADDR_W - OFS_W
) (
   input  logic signed [AIN_W-1:0] addr_in,
   output logic [LIDX_W-1:0]       line_idx,
   output logic [OFS_W-1:0]        word_ofs
);
   // A power-of-two size makes the modulo a plain truncation of the
   // two's-complement value, which is also correct for negative inputs.
   logic [ADDR_W-1:0] wrapped;

   generate
      if (AIN_W == ADDR_W) begin : g_exact
         assign wrapped = addr_in;
      end else begin : g_trunc
         logic unused_hi;
         assign wrapped   = addr_in[ADDR_W-1:0];
         assign unused_hi = ^addr_in[AIN_W-1:ADDR_W];
      end
   endgenerate

   assign line_idx = wrapped[ADDR_W-1:OFS_W];
   assign word_ofs = wrapped[OFS_W-1:0];
endmodule

// File: rtl/lat_mem_own_ctl.sv
module lat_mem_own_ctl #(
   parameter int ID_W  = 4,
   parameter int DELAY = 3,
   localparam int CNT_W = (DELAY > 0) ? $clog2(DELAY + 1) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            poll_valid,
   input  logic [ID_W-1:0] poll_id,
   output logic            fire,
   output logic            reject
);
   logic null_id;
   logic claim;

   assign null_id = (poll_id == '0);
   assign reject  = poll_valid && null_id;

   generate
      if (DELAY == 0) begin : g_nowait
         // zero latency: any legal poll completes at once, no owner is kept
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign claim      = poll_valid && !null_id;
         assign fire       = claim;
      end else begin : g_countdown
         logic [ID_W-1:0]  owner_q;
         logic [CNT_W-1:0] cnt_q;

         assign claim = poll_valid && !null_id &&
                        ((owner_q == '0) || (owner_q == poll_id));
         assign fire  = claim && (cnt_q == '0);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               owner_q <= '0;
               cnt_q   <= CNT_W'(DELAY);
            end else if (fire) begin
               owner_q <= '0;
               cnt_q   <= CNT_W'(DELAY);
            end else if (claim) begin
               owner_q <= poll_id;
               cnt_q   <= cnt_q - 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lat_mem_line_store.sv
module lat_mem_line_store
   import lat_mem_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   localparam int LIDX_W = ADDR_W - OFS_W,
   localparam int LINES  = 1 << LIDX_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  acc_kind_e                    kind,
   input  logic [LIDX_W-1:0]            line_idx,
   input  logic [OFS_W-1:0]             word_ofs,
   input  logic [DATA_W-1:0]            wr_word,
   input  logic [LINE_WORDS*DATA_W-1:0] wr_line,
   output logic [LINE_WORDS*DATA_W-1:0] rd_line
);
   // one independent word lane per position in the line
   generate
      for (genvar k = 0; k < LINE_WORDS; k++) begin : g_lane
         logic [DATA_W-1:0] lane_q [LINES];
         logic              lane_we;
         logic [DATA_W-1:0] lane_wd;

         assign lane_we = wr_en &&
                          ((kind == ACC_LINE) || (word_ofs == OFS_W'(k)));
         assign lane_wd = (kind == ACC_LINE) ? wr_line[k*DATA_W +: DATA_W] : wr_word;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < LINES; i++) lane_q[i] <= '0;
            end else if (lane_we) begin
               lane_q[line_idx] <= lane_wd;
            end
         end

         assign rd_line[k*DATA_W +: DATA_W] = lane_q[line_idx];
      end
   endgenerate
endmodule

// File: rtl/lat_mem.sv
module lat_mem
   import lat_mem_pkg::*;
#(
   parameter int ID_W   = 4,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int AIN_W  = 16,
   parameter int DELAY  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [ID_W-1:0]              req_id,
   input  logic                         req_wr,
   input  logic                         req_line,
   input  logic signed [AIN_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]            req_wdata,
   input  logic [4*DATA_W-1:0]          req_wline,
   output logic                         done,
   output logic                         err,
   output logic [DATA_W-1:0]            rdata,
   output logic [4*DATA_W-1:0]          rline
);
   localparam int LIDX_W = ADDR_W - OFS_W;

   generate
      if (ADDR_W <= OFS_W) begin : g_bad_addr
         $error("lat_mem: ADDR_W must exceed the word-offset width");
      end
      if (AIN_W < ADDR_W) begin : g_bad_ain
         $error("lat_mem: AIN_W must be at least ADDR_W");
      end
      if (DELAY < 0) begin : g_bad_delay
         $error("lat_mem: DELAY must not be negative");
      end
      if (ID_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("lat_mem: ID_W and DATA_W must be positive");
      end
      if (LINE_WORDS != 4) begin : g_bad_line
         $error("lat_mem: port widths assume four words per line");
      end
   endgenerate

   logic [LIDX_W-1:0] line_idx;
   logic [OFS_W-1:0]  word_ofs;
   logic              fire;
   acc_kind_e         kind;

   assign kind = req_line ? ACC_LINE : ACC_WORD;

   lat_mem_addr_wrap #(.AIN_W(AIN_W), .ADDR_W(ADDR_W)) u_wrap (
      .addr_in  (req_addr),
      .line_idx (line_idx),
      .word_ofs (word_ofs)
   );

   lat_mem_own_ctl #(.ID_W(ID_W), .DELAY(DELAY)) u_own (
      .clk        (clk),
      .rst_n      (rst_n),
      .poll_valid (req_valid),
      .poll_id    (req_id),
      .fire       (fire),
      .reject     (err)
   );

   lat_mem_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fire && req_wr),
      .kind     (kind),
      .line_idx (line_idx),
      .word_ofs (word_ofs),
      .wr_word  (req_wdata),
      .wr_line  (req_wline),
      .rd_line  (rline)
   );

   assign done = fire;

   always_comb begin
      rdata = '0;
      for (int k = 0; k < LINE_WORDS; k++) begin
         if (word_ofs == OFS_W'(k)) rdata = rline[k*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/lat_mem_chk.sv
module lat_mem_chk #(
   parameter int ID_W  = 4,
   parameter int DELAY = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [ID_W-1:0] req_id,
   input logic            done,
   input logic            err
);
   // polls since the last completion that were neither refused nor completing
   logic [31:0] since_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                    since_q <= '0;
      else if (done)                 since_q <= '0;
      else if (req_valid && !err && since_q != 32'hFFFF_FFFF)
                                     since_q <= since_q + 1;
   end

   // R2
   done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_valid && req_id != '0));

   // R6
   null_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_id == '0) |-> !done);

   // R6
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err}));

   // R3
   latency_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since_q >= 32'(DELAY)));

   generate
      if (DELAY > 0) begin : g_gap
         // R5
         no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> !done);
      end
   endgenerate
endmodule

bind lat_mem lat_mem_chk #(.ID_W(ID_W), .DELAY(DELAY)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_id    (req_id),
   .done      (done),
   .err       (err)
);

// File: tb/lat_mem_tb_top.sv
module lat_mem_tb_top;
   localparam int ID_W   = 4;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;
   localparam int AIN_W  = 16;
   localparam int DELAY  = 3;
   localparam int WORDS  = 1 << ADDR_W;

   logic                     clk = 1'b0;
   logic                     rst_n;
   logic                     req_valid;
   logic [ID_W-1:0]          req_id;
   logic                     req_wr;
   logic                     req_line;
   logic signed [AIN_W-1:0]  req_addr;
   logic [DATA_W-1:0]        req_wdata;
   logic [4*DATA_W-1:0]      req_wline;
   logic                     done;
   logic                     err;
   logic [DATA_W-1:0]        rdata;
   logic [4*DATA_W-1:0]      rline;

   always #5 clk = ~clk;

   lat_mem #(.ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .AIN_W(AIN_W),
             .DELAY(DELAY)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_wr(req_wr), .req_line(req_line), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_wline(req_wline), .done(done), .err(err),
      .rdata(rdata), .rline(rline)
   );

   // behavioural reference
   logic [DATA_W-1:0] mem_m [WORDS];
   int owner_m;
   int cnt_m;
   bit last_done;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   function automatic int wrap(input int a);
      return ((a % WORDS) + WORDS) % WORDS;
   endfunction

   task automatic cmp(input string tag, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic poll(input int id, input bit wr, input bit ln, input int addr,
                       input logic [DATA_W-1:0] wd, input logic [4*DATA_W-1:0] wl,
                       input string tag);
      bit e_err, e_done;
      int a, lb;
      @(negedge clk);
      req_valid = 1'b1;
      req_id    = ID_W'(id);
      req_wr    = wr;
      req_line  = ln;
      req_addr  = AIN_W'(addr);
      req_wdata = wd;
      req_wline = wl;
      #1;
      e_err  = (id == 0);
      e_done = !e_err && (owner_m == 0 || owner_m == id) && cnt_m == 0;
      a  = wrap(addr);
      lb = (a / 4) * 4;
      cmp({tag, " err"},  DATA_W'(err),  DATA_W'(e_err));
      cmp({tag, " done"}, DATA_W'(done), DATA_W'(e_done));
      if (e_done && !wr) begin
         if (ln) begin
            for (int k = 0; k < 4; k++)
               cmp({tag, " rline"}, rline[k*DATA_W +: DATA_W], mem_m[lb + k]);
         end else begin
            cmp({tag, " rdata"}, rdata, mem_m[a]);
         end
      end
      @(posedge clk);
      if (e_done) begin
         if (wr) begin
            if (ln) for (int k = 0; k < 4; k++) mem_m[lb + k] = wl[k*DATA_W +: DATA_W];
            else    mem_m[a] = wd;
         end
         owner_m = 0;
         cnt_m   = DELAY;
      end else if (!e_err && (owner_m == 0 || owner_m == id)) begin
         owner_m = id;
         cnt_m   = cnt_m - 1;
      end
      last_done = e_done;
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      req_valid = 1'b0;
      req_id    = '0;
      #1;
      cmp({tag, " idle done"}, DATA_W'(done), '0);
      cmp({tag, " idle err"},  DATA_W'(err),  '0);
      @(posedge clk);
      last_done = 1'b0;
   endtask

   task automatic access(input int id, input bit wr, input bit ln, input int addr,
                         input logic [DATA_W-1:0] wd, input logic [4*DATA_W-1:0] wl,
                         input string tag);
      int guard = 0;
      last_done = 1'b0;
      while (!last_done && guard < 20) begin
         poll(id, wr, ln, addr, wd, wl, tag);
         guard++;
      end
      cmp({tag, " completed"}, DATA_W'(last_done), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < WORDS; i++) mem_m[i] = '0;
      owner_m = 0;
      cnt_m   = DELAY;
      rst_n = 1'b0;
      req_valid = 1'b0; req_id = '0; req_wr = 1'b0; req_line = 1'b0;
      req_addr = '0; req_wdata = '0; req_wline = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs quiet in reset
      cmp("R1 reset done", DATA_W'(done), '0);
      cmp("R1 reset err",  DATA_W'(err),  '0);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1");

      // R1: fresh line reads zero; R3 counts polls
      access(1, 0, 1, 40, '0, '0, "R1 R3 fresh line");

      // R7 word write and read back, R3 latency
      access(1, 1, 0, 5, 32'hCAFE_0005, '0, "R7 R3 word write");
      access(1, 0, 0, 5, '0, '0, "R7 word read");

      // R10: idle cycles inside an access do not advance it
      poll(2, 1, 0, 6, 32'h0000_0606, '0, "R10 first poll");
      idle("R10");
      idle("R10");
      access(2, 1, 0, 6, 32'h0000_0606, '0, "R10 resume");

      // R4/R5: two requesters interleaved
      for (int i = 0; i < 4; i++) begin
         poll(3, 1, 0, 9, 32'h3333_0009, '0, "R4 owner");
         poll(4, 1, 0, 10, 32'h4444_000A, '0, "R4 other");
      end
      access(4, 1, 0, 10, 32'h4444_000A, '0, "R5 second full wait");
      access(3, 0, 0, 9, '0, '0, "R4 read owner data");
      access(3, 0, 0, 10, '0, '0, "R5 read second data");

      // R6: null id alone and inside an access
      poll(0, 1, 0, 5, 32'hDEAD_DEAD, '0, "R6 null idle");
      poll(5, 1, 0, 12, 32'h5555_000C, '0, "R6 owner start");
      poll(0, 1, 0, 12, 32'hDEAD_DEAD, '0, "R6 null inside");
      access(5, 1, 0, 12, 32'h5555_000C, '0, "R6 owner finish");
      access(5, 0, 0, 5, '0, '0, "R6 no write");

      // R8/R9: line write at negative address, read via other alias
      access(6, 1, 1, -3, '0, {32'hA3A3_A3A3, 32'hA2A2_A2A2, 32'hA1A1_A1A1, 32'hA0A0_A0A0},
             "R8 R9 line write neg");
      access(6, 0, 1, 255, '0, '0, "R8 line read");
      access(6, 0, 0, 32767, '0, '0, "R9 max addr word");
      access(7, 0, 0, -4, '0, '0, "R9 neg word");

      // R9: above-size address aliases low word
      access(7, 1, 0, 300, 32'h0000_012C, '0, "R9 high write");
      access(7, 0, 0, 44, '0, '0, "R9 alias read");
      access(8, 1, 0, -32768, 32'h8000_0000, '0, "R9 min addr write");
      access(8, 0, 1, 0, '0, '0, "R8 R9 line 0 read");

      // R8: word write into a line then line read
      access(9, 1, 0, 42, 32'h0000_2A2A, '0, "R8 word in line");
      access(9, 0, 1, 41, '0, '0, "R8 line view");

      idle("R1 end");
      finish_run();
   end
endmodule